// File: doc/BRIEF.md
# Booth-recoded serial-by-parallel multiplier

This block multiplies a signed parallel coefficient by a signed operand that arrives one bit per clock, least significant bit first. The coefficient is recoded into radix-2 Booth digits, one per cell of a chain of bit-serial adders. Each cell adds plus, minus or zero times a suitably delayed copy of the operand stream into a running sum stream. Each cell registers its own sum bit and its own carry, so no carry ripples between cells and the critical path is one full adder.

A frame begins with a one-cycle start pulse that carries operand bit 0 and samples the coefficient. The operand supplies its XW bits. For the remaining CW cycles of the XW+CW cycle frame, the block repeats the operand's sign bit itself and ignores the serial input pin. The full-width product then leaves the last cell serially, LSB first, under a valid flag. Frames may follow one another with no gap.

Top module: `booth_serial_mult`

## Requirements
- R1: For each accepted frame, the N = XW+CW output bits, LSB first, equal the N-bit two's complement product of the signed XW-bit operand and the signed CW-bit coefficient.
- R2: Count the edge that samples an accepted frame start as edge 1. Product bit k is then presented on prod_bit after edge k+CW, and bit 0 therefore first appears after edge CW.
- R3: prod_vld is high for exactly N cycles per accepted frame, and it stays high without a gap across back-to-back frames.
- R4: During frame cycles XW to N-1, the op_bit pin is ignored, and the operand's bit XW-1 is used as the sign padding.
- R5: The coefficient is sampled only in the cycle of an accepted frame start; later changes to coef do not affect that frame's product.
- R6: frame_go is ignored while a frame's N input cycles are in progress (cycles 1 to N-1). It is accepted in the cycle right after the last input cycle, and in any later cycle.
- R7: While reset is held, and after its release with no frame started, prod_vld and prod_bit are 0.
- R8: Corner operands give exact results: the most negative value times the most negative value, the largest positive values, zero and -1 factors, and coefficients whose Booth digits are all non-zero (alternating bit patterns).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_go | input | 1 | Frame start pulse, coincident with operand bit 0 |
| op_bit | input | 1 | Serial operand bit, LSB first |
| coef | input | CW | Signed coefficient, sampled at an accepted frame start |
| prod_bit | output | 1 | Serial product bit, LSB first |
| prod_vld | output | 1 | High while prod_bit carries a product bit |

## Verification
The bench builds the block with its default widths: a 20-bit operand, a 16-bit coefficient and a 36-cycle frame. With these widths, the most negative times most negative product sets bit 34 alone. A new frame also enters the early cells while the last cells are still draining the previous one, which exercises the per-cell digit latches and blank flags. Back-to-back random frames, a second frame start mid-frame and one in the last input cycle, and noise on the pin and coefficient after sampling all stay inside a single 36-bit compare per frame.

// File: rtl/booth_serial_mult.sv
module booth_serial_mult #(
  parameter int XW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  input  logic          op_bit,
  input  logic [CW-1:0] coef,
  output logic          prod_bit,
  output logic          prod_vld
);
  localparam int N  = XW + CW;
  localparam int TW = $clog2(N + 1);

  logic          act;
  logic [TW-1:0] cnt;
  logic          sgn_q;
  logic [CW-1:0] coef_q;
  logic          take, live, x_eff;
  logic [TW-1:0] pos_t;

  assign take  = frame_go & ~act;
  assign live  = take | act;
  assign pos_t = take ? '0 : cnt;
  assign x_eff = (pos_t < TW'(XW)) ? op_bit : sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      sgn_q  <= 1'b0;
      coef_q <= '0;
    end else begin
      if (take) begin
        act    <= 1'b1;
        cnt    <= TW'(1);
        coef_q <= coef;
      end else if (act) begin
        cnt <= cnt + TW'(1);
        if (cnt == TW'(N - 1)) act <= 1'b0;
      end
      if (live && pos_t == TW'(XW - 1)) sgn_q <= op_bit;
    end
  end

  // sum, frame flag and start token advance one cell per clock; operand two per cell
  logic [CW:0]   s_c, f_c;
  logic [CW-1:0] t_c, xd_c, xs_c;

  assign s_c[0]  = 1'b0;
  assign f_c[0]  = live;
  assign t_c[0]  = take;
  assign xd_c[0] = x_eff;
  assign xs_c[0] = take;

  for (genvar j = 0; j < CW; j++) begin : g_cell
    logic cb, cbl, pos, neg, blank, xm, term, cin, sum, cout;
    logic s_q, cy_q, pos_q, neg_q, bl_q, f_q;

    if (j == 0) begin : g_src0
      assign cb  = coef[0];
      assign cbl = 1'b0;
    end else begin : g_srcn
      assign cb  = coef_q[j];
      assign cbl = coef_q[j-1];
    end

    assign pos   = t_c[j] ? (cbl & ~cb) : pos_q;
    assign neg   = t_c[j] ? (cb & ~cbl) : neg_q;
    assign blank = xs_c[j] ? 1'b0 : (t_c[j] ? 1'b1 : bl_q);
    assign xm    = ~blank & xd_c[j];
    assign term  = neg ? ~xm : (pos & xm);
    assign cin   = t_c[j] ? neg : cy_q;
    assign sum   = s_c[j] ^ term ^ cin;
    assign cout  = (s_c[j] & term) | (s_c[j] & cin) | (term & cin);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q   <= 1'b0;
        cy_q  <= 1'b0;
        pos_q <= 1'b0;
        neg_q <= 1'b0;
        bl_q  <= 1'b0;
        f_q   <= 1'b0;
      end else begin
        s_q   <= sum;
        cy_q  <= cout;
        pos_q <= pos;
        neg_q <= neg;
        bl_q  <= blank;
        f_q   <= f_c[j];
      end
    end

    assign s_c[j+1] = s_q;
    assign f_c[j+1] = f_q;

    if (j < CW - 1) begin : g_fwd
      logic t_q, x1_q, x2_q, xs1_q, xs2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          t_q   <= 1'b0;
          x1_q  <= 1'b0;
          x2_q  <= 1'b0;
          xs1_q <= 1'b0;
          xs2_q <= 1'b0;
        end else begin
          t_q   <= t_c[j];
          x1_q  <= xd_c[j];
          x2_q  <= x1_q;
          xs1_q <= xs_c[j];
          xs2_q <= xs1_q;
        end
      end
      assign t_c[j+1]  = t_q;
      assign xd_c[j+1] = x2_q;
      assign xs_c[j+1] = xs2_q;
    end
  end

  assign prod_bit = s_c[CW];
  assign prod_vld = f_c[CW];

  logic [TW-1:0] opos;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        opos <= '0;
    else if (prod_vld) opos <= (opos == TW'(N - 1)) ? '0 : opos + TW'(1);
    else               opos <= '0;
  end

  assert_go_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && act) |=> (cnt == $past(cnt) + TW'(1)));

  assert_go_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && !act) |=> (act && cnt == TW'(1)));

  assert_pad_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt == TW'(XW)) |-> (x_eff == $past(op_bit)));

  assert_pad_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt > TW'(XW)) |-> (x_eff == $past(x_eff)));

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prod_vld && $past(prod_vld)) |-> ($past(opos) == TW'(N - 1)));
endmodule

// File: tb/booth_serial_mult_tb_top.sv
`timescale 1ns/1ps
module booth_serial_mult_tb_top;
  localparam int XW = 20;
  localparam int CW = 16;
  localparam int N  = XW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_go = 1'b0;
  logic          op_bit = 1'b0;
  logic [CW-1:0] coef = '0;
  logic          prod_bit, prod_vld;

  always #2 clk = ~clk;

  booth_serial_mult #(.XW(XW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .op_bit(op_bit),
    .coef(coef), .prod_bit(prod_bit), .prod_vld(prod_vld));

  int total = 0, bad = 0, cyc = 0, nb = 0;
  bit ended = 1'b0, prev_vld = 1'b0;
  longint exp_q[$];
  string  tag_q[$];
  int     stc_q[$];
  logic [N-1:0] acc;
  logic [63:0]  rng = 64'h9E3779B97F4A7C15;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: assembles each output frame and compares it with the queued product
  always @(negedge clk) begin
    longint e;
    string  tg;
    int     st;
    if (rst_n && !ended) begin
      if (prod_vld) begin
        if (nb == 0) begin
          if (stc_q.size() == 0) chk(1'b0, "R3 unexpected frame", 1, 0);
          else begin
            st = stc_q.pop_front();
            chk(cyc - st == CW, "R2 latency", cyc - st, CW);
          end
        end
        acc[nb] = prod_bit;
        nb++;
        if (nb == N) begin
          nb = 0;
          if (exp_q.size() == 0) chk(1'b0, "R3 extra product", acc, 0);
          else begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(acc == e[N-1:0], tg, acc, e[N-1:0]);
          end
        end
      end else if (prev_vld) begin
        chk(nb == 0, "R3 frame length", nb, 0);
        nb = 0;
      end
      prev_vld = prod_vld;
    end
  end

  // driver: one full frame; noisy scrambles pad bits and coef after sampling
  task automatic send(input logic signed [XW-1:0] xv, input logic signed [CW-1:0] cv,
                      input string tag, input bit noisy, input int poke);
    longint p;
    p = longint'(xv) * longint'(cv);
    @(negedge clk);
    frame_go = 1'b1;
    op_bit   = xv[0];
    coef     = cv;
    exp_q.push_back(p);
    tag_q.push_back(tag);
    stc_q.push_back(cyc);
    for (int t = 1; t < N; t++) begin
      @(negedge clk);
      frame_go = (t == poke);
      op_bit   = (t < XW) ? xv[t] : (noisy ? t[0] : xv[XW-1]);
      coef     = noisy ? ~cv : cv;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_go = 1'b0;
      op_bit   = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prod_vld == 1'b0, "R7 valid in reset", prod_vld, 0);
    chk(prod_bit == 1'b0, "R7 bit in reset", prod_bit, 0);
    rst_n = 1'b1;
    idle(4);
    chk(prod_vld == 1'b0, "R7 valid idle", prod_vld, 0);
    chk(prod_bit == 1'b0, "R7 bit idle", prod_bit, 0);

    send(20'sd3, 16'sd5, "R1 small", 1'b0, 0);
    idle(5);
    send(-20'sd7, 16'sd11, "R1 mixed sign", 1'b0, 0);
    send(20'sd123456, -16'sd321, "R1 back to back", 1'b0, 0);
    idle(3);

    send(20'sh80000, 16'sh8000, "R8 min times min", 1'b0, 0);
    send(20'sh7FFFF, 16'sh7FFF, "R8 max times max", 1'b0, 0);
    send(20'sh80000, 16'sh7FFF, "R8 min times max", 1'b0, 0);
    send(20'sd0, -16'sd1, "R8 zero operand", 1'b0, 0);
    send(20'sd12345, 16'sd0, "R8 zero coefficient", 1'b0, 0);
    send(-20'sd1, -16'sd1, "R8 minus one squared", 1'b0, 0);
    send(-20'sd99999, 16'sh5555, "R8 alternating 5555", 1'b0, 0);
    send(20'sd77777, 16'shAAAA, "R8 alternating AAAA", 1'b0, 0);
    idle(2);

    send(-20'sd5000, 16'sd1234, "R4 R5 noisy pad and coef", 1'b1, 0);
    send(20'sd262143, -16'sd32768, "R4 R5 noisy extreme", 1'b1, 0);
    idle(2);

    send(20'sd4321, -16'sd77, "R6 start mid frame", 1'b0, 7);
    send(-20'sd1, 16'sd3, "R6 start last cycle", 1'b0, N - 1);
    idle(1);

    for (int i = 0; i < 24; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      send(rng[19:0], rng[40:25], "R1 random back to back", rng[50], 0);
    end
    idle(CW + N + 10);

    chk(exp_q.size() == 0, "R3 all frames delivered", exp_q.size(), 0);
    chk(prod_vld == 1'b0, "R3 valid low after last frame", prod_vld, 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog expired actual=%0d expected=0", exp_q.size());
    finish_run();
  end
endmodule